// File: doc/BRIEF.md
# Focus and Track-Jump Servo Sequencer

This block runs the timed step sequences that an optical pickup needs to pull the focus loop in and to move the beam across tracks. A controller writes a command code and a direction bit. The sequencer then works through the steps of that command without further help. It drives the focus search and the focus servo enable. It also drives the enables and the forward and reverse kick lines of the tracking and sled loops. It reads three inputs: the focus-good flag, the focus zero-cross level and the track-crossing pulse.

Every wait is a value in units of a prescaled tick that the controller supplies. There are five waits: a blind time that masks crossing pulses just after a kick, a brake time, a crossing-overflow time, a sled kick time and a focus settle time. A jump ends its braking kick in one of two ways. The single-track jump uses a fixed brake time. The longer jumps brake until the crossing pulses slow down, which is when no crossing arrives for the overflow time. Any new command aborts the sequence that is running and starts from the first step. A busy flag covers the whole sequence, and a one-cycle done strobe marks its normal end.

Top module: `pickup_seq`

## Requirements
- R1: After reset all servo enables, kick lines, focus search, busy and done are low.
- R2: Command codes are 1 for focus pull-in, 2 for the single-track jump, 3 for the ten-track jump, 4 for the 2N-track jump and 5 for the sled-only move. Codes 0, 6 and 7 stop the sequencer. A stop goes idle within one cycle, with kicks and search off, servo enables unchanged and no done strobe. Any command given while a sequence runs aborts it and restarts at the first step of the new command.
- R3: Focus pull-in clears the focus servo and raises focus search until focus-good is high. The zero-cross input must then stay high for wait_e×TICK_DIV consecutive cycles, and any low restarts this window. The first low after that sets the focus servo on and search off.
- R4: The single-track jump clears the tracking and sled servos and kicks tracking in the jump direction. Crossing pulses during the wait_a blind window are ignored. The first rising crossing edge after the window starts a reverse kick lasting exactly wait_b×TICK_DIV cycles. After that, tracking and sled are on.
- R5: The ten-track jump counts 5 rising crossing edges after the blind window. It then reverse-kicks until no crossing edge has arrived for wait_c×TICK_DIV cycles, where each edge restarts that window. Tracking and sled are then on.
- R6: The 2N-track jump kicks tracking and sled together and counts track_n crossing edges. It brakes tracking as in R5. It then sets tracking on while the sled keeps kicking for wait_d×TICK_DIV cycles, and then sets the sled on. No kick line is active while its own servo is on.
- R7: The sled-only move clears tracking and sled and kicks only the sled. After the blind window it counts track_n crossing edges. On the last edge it stops kicking and leaves both servos off, with no brake kick.
- R8: cmd_dir 0 selects forward and 1 selects reverse for the jump kick. The brake kick always uses the opposite direction, and the forward and reverse lines of a loop are never high together.
- R9: busy is high from the cycle after a start command until the sequence ends. done is high for exactly one cycle, in the first cycle with busy low after a normal end. An aborted or stopped sequence gives no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (R2) |
| cmd_dir | input | 1 | Jump direction, 0 forward, 1 reverse |
| track_n | input | CNT_W | Crossing count for 2N jump and sled move |
| wait_a | input | TIME_W | Blind time in ticks |
| wait_b | input | TIME_W | Brake time in ticks |
| wait_c | input | TIME_W | Crossing overflow time in ticks |
| wait_d | input | TIME_W | Sled kick time in ticks |
| wait_e | input | TIME_W | Focus settle time in ticks |
| focus_ok | input | 1 | Focus-good flag |
| focus_zc | input | 1 | Focus zero-cross level |
| cross_pulse | input | 1 | Track-crossing pulse, counted on rising edges |
| focus_search | output | 1 | Focus search drive |
| focus_on | output | 1 | Focus servo enable |
| track_on | output | 1 | Tracking servo enable |
| sled_on | output | 1 | Sled servo enable |
| track_kick_fwd | output | 1 | Tracking forward kick |
| track_kick_rev | output | 1 | Tracking reverse kick |
| sled_kick_fwd | output | 1 | Sled forward kick |
| sled_kick_rev | output | 1 | Sled reverse kick |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle end strobe |

## Verification
Every result here follows one clock edge after the input that causes it. A command, a crossing edge that ends a count, or the zero-cross low that ends pull-in therefore shows at the next sample point. A wait of W ticks keeps its state for exactly W×TICK_DIV cycles. The bench drives inputs and samples outputs at the falling edge. It measures kick widths by counting the falling-edge samples in which the kick line is high, and compares them with exact counts worked out from the waits. These are 8 for a two-tick brake, and 13 when a crossing edge five cycles into an overflow brake restarts its window. Focus settle is checked on both sides of its boundary, with a zero-cross high of 11 cycles that must be rejected and one of 12 cycles that must be accepted.

// File: rtl/pickup_seq_pkg.sv
package pickup_seq_pkg;

   typedef enum logic [2:0] {
      CMD_STOP   = 3'd0,
      CMD_FOCUS  = 3'd1,
      CMD_JUMP1  = 3'd2,
      CMD_JUMP10 = 3'd3,
      CMD_JUMP2N = 3'd4,
      CMD_MOVE   = 3'd5
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_F_SEARCH,
      ST_F_HOLD,
      ST_F_FALL,
      ST_BLIND,
      ST_COUNT,
      ST_BRAKE_B,
      ST_BRAKE_C,
      ST_KICK_D
   } state_e;

   localparam int JUMP10_CROSSINGS = 5;

endpackage

// File: rtl/pickup_seq_timer.sv
module pickup_seq_timer #(
   parameter int TICK_DIV = 4,
   parameter int TIME_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   output logic              time_up
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam bit POW2  = (TICK_DIV & (TICK_DIV - 1)) == 0;

   logic [PRE_W-1:0]  pre_q;
   logic [TIME_W-1:0] rem_q;
   logic              tick;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("pickup_seq_timer: TICK_DIV must be at least 2");
      end
      if (POW2) begin : g_tick_pow2
         assign tick = &pre_q;
      end else begin : g_tick_cmp
         assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         rem_q <= '0;
      end else if (load) begin
         pre_q <= '0;
         rem_q <= load_val;
      end else if (rem_q != '0) begin
         if (tick) begin
            pre_q <= '0;
            rem_q <= rem_q - TIME_W'(1);
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end

   // Expiry lands on the edge that would take the count to zero, so a
   // load of W ticks lasts exactly W*TICK_DIV cycles in the caller's state.
   assign time_up = (rem_q == '0) || ((rem_q == TIME_W'(1)) && tick);

   // R4
   rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/pickup_seq_xcount.sv
module pickup_seq_xcount #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             pulse,
   input  logic [CNT_W-1:0] target,
   output logic             xedge,
   output logic             hit
);
   logic             prev_q;
   logic [CNT_W-1:0] cnt_q;

   assign xedge = pulse & ~prev_q;
   // A target of zero wraps to the full 2^CNT_W count.
   assign hit   = enable & xedge & (cnt_q == (target - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= pulse;
         if (!enable)
            cnt_q <= '0;
         else if (xedge)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R4
   blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt_q == '0));

endmodule

// File: rtl/pickup_seq.sv
module pickup_seq
   import pickup_seq_pkg::*;
#(
   parameter int TICK_DIV = 4,
   parameter int TIME_W   = 8,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic              cmd_dir,
   input  logic [CNT_W-1:0]  track_n,
   input  logic [TIME_W-1:0] wait_a,
   input  logic [TIME_W-1:0] wait_b,
   input  logic [TIME_W-1:0] wait_c,
   input  logic [TIME_W-1:0] wait_d,
   input  logic [TIME_W-1:0] wait_e,
   input  logic              focus_ok,
   input  logic              focus_zc,
   input  logic              cross_pulse,
   output logic              focus_search,
   output logic              focus_on,
   output logic              track_on,
   output logic              sled_on,
   output logic              track_kick_fwd,
   output logic              track_kick_rev,
   output logic              sled_kick_fwd,
   output logic              sled_kick_rev,
   output logic              busy,
   output logic              done
);
   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("pickup_seq: CNT_W must hold the ten-track count");
      end
      if (TIME_W < 1) begin : g_bad_time
         $error("pickup_seq: TIME_W must be positive");
      end
   endgenerate

   state_e            state_q, state_d;
   cmd_e              kind_q, kind_d;
   logic              dir_q, dir_d;
   logic              focus_q, focus_d;
   logic              trk_q, trk_d;
   logic              sled_q, sled_d;
   logic              done_q, done_d;
   logic              tmr_load;
   logic [TIME_W-1:0] tmr_val;
   logic              time_up;
   logic              cnt_en, xedge, hit;
   logic [CNT_W-1:0]  target;

   pickup_seq_timer #(.TICK_DIV(TICK_DIV), .TIME_W(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .time_up  (time_up)
   );

   always_comb begin
      case (kind_q)
         CMD_JUMP1:  target = CNT_W'(1);
         CMD_JUMP10: target = CNT_W'(JUMP10_CROSSINGS);
         default:    target = track_n;
      endcase
   end

   assign cnt_en = (state_q == ST_COUNT);

   pickup_seq_xcount #(.CNT_W(CNT_W)) u_xcount (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (cnt_en),
      .pulse  (cross_pulse),
      .target (target),
      .xedge  (xedge),
      .hit    (hit)
   );

   always_comb begin
      state_d  = state_q;
      kind_d   = kind_q;
      dir_d    = dir_q;
      focus_d  = focus_q;
      trk_d    = trk_q;
      sled_d   = sled_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = wait_a;
      if (cmd_valid) begin
         dir_d = cmd_dir;
         case (cmd_e'(cmd_code))
            CMD_FOCUS: begin
               kind_d  = CMD_FOCUS;
               state_d = ST_F_SEARCH;
               focus_d = 1'b0;
            end
            CMD_JUMP1, CMD_JUMP10, CMD_JUMP2N, CMD_MOVE: begin
               kind_d   = cmd_e'(cmd_code);
               state_d  = ST_BLIND;
               tmr_load = 1'b1;
               tmr_val  = wait_a;
               trk_d    = 1'b0;
               sled_d   = 1'b0;
            end
            default: state_d = ST_IDLE;
         endcase
      end else begin
         case (state_q)
            ST_F_SEARCH:
               if (focus_ok) begin
                  state_d  = ST_F_HOLD;
                  tmr_load = 1'b1;
                  tmr_val  = wait_e;
               end
            ST_F_HOLD:
               if (!focus_zc) begin
                  tmr_load = 1'b1;
                  tmr_val  = wait_e;
               end else if (time_up) begin
                  state_d = ST_F_FALL;
               end
            ST_F_FALL:
               if (!focus_zc) begin
                  focus_d = 1'b1;
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            ST_BLIND:
               if (time_up) state_d = ST_COUNT;
            ST_COUNT:
               if (hit) begin
                  case (kind_q)
                     CMD_JUMP1: begin
                        state_d  = ST_BRAKE_B;
                        tmr_load = 1'b1;
                        tmr_val  = wait_b;
                     end
                     CMD_JUMP10, CMD_JUMP2N: begin
                        state_d  = ST_BRAKE_C;
                        tmr_load = 1'b1;
                        tmr_val  = wait_c;
                     end
                     default: begin
                        trk_d   = 1'b0;
                        sled_d  = 1'b0;
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                     end
                  endcase
               end
            ST_BRAKE_B:
               if (time_up) begin
                  trk_d   = 1'b1;
                  sled_d  = 1'b1;
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            ST_BRAKE_C:
               if (xedge) begin
                  tmr_load = 1'b1;
                  tmr_val  = wait_c;
               end else if (time_up) begin
                  trk_d = 1'b1;
                  if (kind_q == CMD_JUMP2N) begin
                     state_d  = ST_KICK_D;
                     tmr_load = 1'b1;
                     tmr_val  = wait_d;
                  end else begin
                     sled_d  = 1'b1;
                     done_d  = 1'b1;
                     state_d = ST_IDLE;
                  end
               end
            ST_KICK_D:
               if (time_up) begin
                  sled_d  = 1'b1;
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= CMD_STOP;
         dir_q   <= 1'b0;
         focus_q <= 1'b0;
         trk_q   <= 1'b0;
         sled_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         kind_q  <= kind_d;
         dir_q   <= dir_d;
         focus_q <= focus_d;
         trk_q   <= trk_d;
         sled_q  <= sled_d;
         done_q  <= done_d;
      end
   end

   logic jump_ph, brake_ph, trk_jump, sled_act;

   assign jump_ph  = (state_q == ST_BLIND) || (state_q == ST_COUNT);
   assign brake_ph = (state_q == ST_BRAKE_B) || (state_q == ST_BRAKE_C);
   assign trk_jump = jump_ph && (kind_q != CMD_MOVE);
   assign sled_act = (jump_ph && ((kind_q == CMD_JUMP2N) || (kind_q == CMD_MOVE)))
                  || ((kind_q == CMD_JUMP2N) &&
                      ((state_q == ST_BRAKE_C) || (state_q == ST_KICK_D)));

   assign track_kick_fwd = (trk_jump & ~dir_q) | (brake_ph &  dir_q);
   assign track_kick_rev = (trk_jump &  dir_q) | (brake_ph & ~dir_q);
   assign sled_kick_fwd  = sled_act & ~dir_q;
   assign sled_kick_rev  = sled_act &  dir_q;
   assign focus_search   = (state_q == ST_F_SEARCH) || (state_q == ST_F_HOLD)
                        || (state_q == ST_F_FALL);
   assign focus_on       = focus_q;
   assign track_on       = trk_q;
   assign sled_on        = sled_q;
   assign busy           = (state_q != ST_IDLE);
   assign done           = done_q;

   // R8
   kick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(track_kick_fwd && track_kick_rev) && !(sled_kick_fwd && sled_kick_rev));

   // R6
   kick_servo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((track_kick_fwd || track_kick_rev) |-> !track_on) and
      ((sled_kick_fwd || sled_kick_rev) |-> !sled_on));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   focus_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(focus_on) |-> ($past(focus_search) && !$past(focus_zc)));

endmodule

// File: tb/pickup_seq_bench.sv
`timescale 1ns/1ps
module pickup_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_code = 3'd0;
   logic        cmd_dir = 1'b0;
   logic [15:0] track_n = 16'd1;
   logic [7:0]  wait_a = 8'd1, wait_b = 8'd1, wait_c = 8'd1, wait_d = 8'd1, wait_e = 8'd1;
   logic        focus_ok = 1'b0, focus_zc = 1'b0, cross_pulse = 1'b0;
   logic        focus_search, focus_on, track_on, sled_on;
   logic        track_kick_fwd, track_kick_rev, sled_kick_fwd, sled_kick_rev;
   logic        busy, done;

   int n_chk = 0;
   int n_fail = 0;
   int done_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pickup_seq u_pickup_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_dir(cmd_dir), .track_n(track_n), .wait_a(wait_a), .wait_b(wait_b),
      .wait_c(wait_c), .wait_d(wait_d), .wait_e(wait_e), .focus_ok(focus_ok),
      .focus_zc(focus_zc), .cross_pulse(cross_pulse), .focus_search(focus_search),
      .focus_on(focus_on), .track_on(track_on), .sled_on(sled_on),
      .track_kick_fwd(track_kick_fwd), .track_kick_rev(track_kick_rev),
      .sled_kick_fwd(sled_kick_fwd), .sled_kick_rev(sled_kick_rev),
      .busy(busy), .done(done));

   always @(negedge clk) if (rst_n && done) done_cnt++;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] code, input logic dir);
      cmd_valid = 1'b1; cmd_code = code; cmd_dir = dir;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic pulse_cross();
      cross_pulse = 1'b1; @(negedge clk);
      cross_pulse = 1'b0; @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "outputs after reset",
          int'({focus_search, focus_on, track_on, sled_on, track_kick_fwd,
                track_kick_rev, sled_kick_fwd, sled_kick_rev, busy, done}), 0);
   endtask

   task automatic t_focus();
      int d0;
      wait_e = 8'd3;
      d0 = done_cnt;
      send(3'd1, 1'b0);
      chk("R3", "search on start", int'(focus_search), 1);
      chk("R9", "busy on start", int'(busy), 1);
      repeat (5) @(negedge clk);
      chk("R3", "focus off before focus_ok", int'(focus_on), 0);
      focus_ok = 1'b1; @(negedge clk); @(negedge clk);
      focus_zc = 1'b1;
      repeat (11) @(negedge clk);
      focus_zc = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3", "11-cycle zero-cross high rejected", int'(focus_on), 0);
      chk("R3", "search held after rejection", int'(focus_search), 1);
      focus_zc = 1'b1;
      repeat (12) @(negedge clk);
      chk("R3", "servo waits for zero-cross low", int'(focus_on), 0);
      focus_zc = 1'b0;
      @(negedge clk);
      chk("R3", "focus on after 12-cycle high", int'(focus_on), 1);
      chk("R3", "search off", int'(focus_search), 0);
      chk("R9", "done strobe focus", int'(done), 1);
      @(negedge clk); @(negedge clk);
      chk("R9", "one done for focus", done_cnt - d0, 1);
   endtask

   task automatic t_jump1(input logic dir);
      int w;
      logic jk, bk;
      wait_a = 8'd3; wait_b = 8'd2;
      send(3'd2, dir);
      jk = dir ? track_kick_rev : track_kick_fwd;
      chk("R4", "track off at jump", int'({track_on, sled_on}), 0);
      chk("R8", "jump kick follows dir", int'(jk), 1);
      chk("R4", "no sled kick on single jump", int'(sled_kick_fwd | sled_kick_rev), 0);
      repeat (2) @(negedge clk);
      pulse_cross();
      bk = dir ? track_kick_fwd : track_kick_rev;
      chk("R4", "crossing in blind ignored", int'(bk), 0);
      repeat (12) @(negedge clk);
      cross_pulse = 1'b1; @(negedge clk);
      bk = dir ? track_kick_fwd : track_kick_rev;
      chk("R8", "brake kick opposite", int'(bk), 1);
      cross_pulse = 1'b0;
      w = 0;
      while (bk && w < 100) begin
         w++; @(negedge clk);
         bk = dir ? track_kick_fwd : track_kick_rev;
      end
      chk("R4", "brake width wait_b*4", w, 8);
      chk("R4", "servos on after jump", int'({track_on, sled_on}), 3);
      chk("R9", "done after jump", int'(done), 1);
   endtask

   task automatic t_jump10();
      int w;
      wait_a = 8'd1; wait_c = 8'd2;
      send(3'd3, 1'b0);
      repeat (5) @(negedge clk);
      repeat (4) pulse_cross();
      chk("R5", "no brake after 4 crossings", int'(track_kick_rev), 0);
      chk("R5", "still kicking forward", int'(track_kick_fwd), 1);
      cross_pulse = 1'b1; @(negedge clk);
      chk("R5", "brake on 5th crossing", int'(track_kick_rev), 1);
      cross_pulse = 1'b0; w = 1;
      repeat (4) begin @(negedge clk); if (track_kick_rev) w++; end
      cross_pulse = 1'b1; @(negedge clk); if (track_kick_rev) w++;
      cross_pulse = 1'b0;
      while (track_kick_rev && w < 100) begin @(negedge clk); if (track_kick_rev) w++; end
      chk("R5", "overflow brake restarted by crossing", w, 13);
      chk("R5", "servos on after ten-track", int'({track_on, sled_on}), 3);
      chk("R9", "done after ten-track", int'(done), 1);
   endtask

   task automatic t_jump2n();
      int w;
      wait_a = 8'd1; wait_c = 8'd1; wait_d = 8'd2; track_n = 16'd3;
      send(3'd4, 1'b1);
      chk("R6", "track and sled kick reverse", int'({track_kick_rev, sled_kick_rev}), 3);
      repeat (5) @(negedge clk);
      repeat (2) pulse_cross();
      chk("R6", "no brake before N", int'(track_kick_fwd), 0);
      cross_pulse = 1'b1; @(negedge clk);
      chk("R8", "brake forward for reverse jump", int'(track_kick_fwd), 1);
      cross_pulse = 1'b0;
      w = 0;
      while (track_kick_fwd && w < 100) begin w++; @(negedge clk); end
      chk("R6", "overflow brake width", w, 4);
      chk("R6", "track on, sled off", int'({track_on, sled_on}), 2);
      chk("R6", "sled still kicking", int'(sled_kick_rev), 1);
      chk("R9", "no done mid-sequence", int'(done), 0);
      w = 0;
      while (sled_kick_rev && w < 100) begin w++; @(negedge clk); end
      chk("R6", "sled kick time wait_d*4", w, 8);
      chk("R6", "sled on at end", int'(sled_on), 1);
      chk("R9", "done after 2N", int'(done), 1);
   endtask

   task automatic t_move();
      wait_a = 8'd1; track_n = 16'd4;
      send(3'd5, 1'b0);
      chk("R7", "track off, sled kick only",
          int'({track_on, track_kick_fwd, track_kick_rev, sled_kick_fwd}), 1);
      repeat (5) @(negedge clk);
      repeat (3) pulse_cross();
      chk("R7", "sled kick before N", int'(sled_kick_fwd), 1);
      cross_pulse = 1'b1; @(negedge clk);
      cross_pulse = 1'b0;
      chk("R7", "move ends without brake",
          int'({sled_kick_fwd, sled_kick_rev, track_kick_fwd, track_kick_rev, busy}), 0);
      chk("R7", "servos off after move", int'({track_on, sled_on}), 0);
      chk("R9", "done after move", int'(done), 1);
   endtask

   task automatic t_abort();
      int d0;
      wait_a = 8'd1; track_n = 16'd100;
      send(3'd5, 1'b0);
      repeat (5) @(negedge clk);
      repeat (2) pulse_cross();
      d0 = done_cnt;
      wait_a = 8'd3; wait_b = 8'd1;
      send(3'd2, 1'b1);
      chk("R2", "abort switches to jump", int'({sled_kick_fwd, track_kick_rev, busy}), 3);
      pulse_cross();
      chk("R2", "restarted blind ignores crossing", int'(track_kick_fwd), 0);
      repeat (14) @(negedge clk);
      cross_pulse = 1'b1; @(negedge clk); cross_pulse = 1'b0;
      chk("R2", "restarted jump brakes", int'(track_kick_fwd), 1);
      repeat (6) @(negedge clk);
      chk("R9", "aborted move gives no done", done_cnt - d0, 1);
      d0 = done_cnt;
      send(3'd1, 1'b0);
      send(3'd0, 1'b0);
      chk("R2", "stop code 0 idles", int'({busy, focus_search, done}), 0);
      chk("R2", "stop keeps tracking on", int'(track_on), 1);
      send(3'd3, 1'b0);
      send(3'd7, 1'b0);
      chk("R2", "stop code 7 clears kicks",
          int'({busy, track_kick_fwd, track_kick_rev, sled_kick_fwd, sled_kick_rev}), 0);
      repeat (3) @(negedge clk);
      chk("R9", "stops give no done", done_cnt - d0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_focus();
      t_jump1(1'b0);
      t_jump1(1'b1);
      t_jump10();
      t_jump2n();
      t_move();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule